// File: doc/BRIEF.md
# Keyed Watchdog Control Front End

This block is the register front end of a windowed watchdog timer. It sits on a simple memory-mapped bus with a byte address, 32-bit write data, byte strobes, read data, and one-cycle read and write strobes. It holds three registers:

- a static configuration register, holding the clock divider, the period select, two closed-window fractions, a mode bit and a stop-in-sleep bit;
- a window-select register, choosing which closed-window fraction is in force;
- a read-only status register, reporting whether the watchdog is running.

Both control registers are guarded. Every access to them must use all four byte lanes, and every write must carry a per-register key in the top byte. The first accepted write to the configuration register starts the watchdog. From then on, that register stays locked until reset. Any illegal access sends a one-cycle violation pulse toward the system controller, which decides how to escalate.

A small down-counter makes the start and the lock visible. It advances on an external tick through a divide-by-2^CLKDIV prescaler. It is reloaded by an external service strobe. It flags both an early service inside the closed window and an expiry. A separate power-enable input gates the whole bus side.

Top module: `wdg_ctrl_if`

## Requirements
- R1: After reset, the configuration register, the window-select register and the status register all read 0, the watchdog is stopped, and no violation is reported.
- R2: Any read or write to the configuration register (offset 0x0) or the window-select register (offset 0x4) with a byte-strobe value other than 4'hF raises a violation. Such a write changes nothing, and such a read returns 0.
- R3: A write is accepted only when write-data bits [31:24] equal the register's key: 8'hC9 for the configuration register and 8'hBE for the window-select register. Any other key raises a violation and leaves the register unchanged.
- R4: Read-back layout.
  - Configuration register: CLKDIV in [2:0], PER in [5:3], WINDOW0 in [8:6], WINDOW1 in [11:9], MODE in [12], STISM in [13]. Bits [23:14] ignore writes and read 0.
  - Window-select register: WINSEL in bit 0.
  - Status register (offset 0x8): the running flag in bit 0.
  - Bits [31:24] of every register read 0.
- R5: The first key-matched, full-width write to the configuration register stores its fields and sets the running flag.
- R6: While running, a full-width, key-matched configuration write raises a violation and leaves the register unchanged. The window-select register stays writable.
- R7: While power-enable is low, bus writes have no effect, reads return 0, and no access raises a violation.
- R8: The violation output is registered. It is high for exactly the one cycle after the clock edge that samples an offending access or timer event.
- R9: While running and without service, a violation is raised after exactly 2^(8+2*PER) * 2^CLKDIV ticks, and the counter reloads to count the same period again.
- R10: A service while the remaining count exceeds P*(8-W)/8 raises a violation and does not reload the counter. Here P is the period count 2^(8+2*PER), and W is WINDOW1 when WINSEL is 1, otherwise WINDOW0. A service at or below that threshold reloads the counter silently.
- R11: Ticks and service strobes have no effect while the watchdog is stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pwr_en | input | 1 | Power enable; bus accesses take effect only when high |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | 32 | Write data, key in bits [31:24] |
| bus_be | input | 4 | Byte strobes of the access |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe, one access per cycle |
| bus_rdata | output | 32 | Read data, valid in the cycle bus_rd is high |
| tmr_tick | input | 1 | Timer tick enable |
| tmr_svc | input | 1 | Service strobe that restarts the count |
| wdg_viol | output | 1 | One-cycle violation pulse to the system controller |

## Verification
The key byte is swept over all 256 values on both control registers. This separates the one accepted key from its 255 near neighbours, and shows that a foreign key has no effect. The byte-strobe sweep runs all sixteen patterns, to find any partial width that slips through. The period is swept across four PER values with alternating divider settings, counting ticks to one short of expiry and then to expiry. This distinguishes an off-by-one in the reload, the shift or the prescaler. Service strobes placed just above and exactly at the closed-window threshold, with each window select, tell a strict from an inclusive comparison and show whether the right fraction is in force.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned BE_W    = DATA_W / 8;
  localparam int unsigned KEY_LSB = 24;
  localparam int unsigned DIV_W   = 3;
  localparam int unsigned PER_W   = 3;
  localparam int unsigned WIN_W   = 3;
  localparam int unsigned BASE_SH = 8;
  localparam int unsigned CNT_W   = BASE_SH + 2 * ((1 << PER_W) - 1) + 1;
  localparam int unsigned PRE_W   = (1 << DIV_W) - 1;

  localparam logic [7:0] CFG_KEY = 8'hC9;
  localparam logic [7:0] SEL_KEY = 8'hBE;

  localparam int unsigned OFF_CFG  = 0;
  localparam int unsigned OFF_SEL  = 4;
  localparam int unsigned OFF_STAT = 8;

  typedef struct packed {
    logic             stism;
    logic             mode;
    logic [WIN_W-1:0] win1;
    logic [WIN_W-1:0] win0;
    logic [PER_W-1:0] per;
    logic [DIV_W-1:0] clkdiv;
  } wdg_cfg_t;

  localparam int unsigned CFG_W = $bits(wdg_cfg_t);

  typedef enum logic [1:0] {
    REG_CFG  = 2'd0,
    REG_SEL  = 2'd1,
    REG_STAT = 2'd2,
    REG_NONE = 2'd3
  } wdg_reg_e;
endpackage

// File: rtl/wdg_decode.sv
module wdg_decode
  import wdg_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic [ADDR_W-1:0] addr,
  output wdg_reg_e          sel
);
  localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(OFF_CFG);
  localparam logic [ADDR_W-1:0] A_SEL  = ADDR_W'(OFF_SEL);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFF_STAT);

  always_comb begin
    if (addr == A_CFG)       sel = REG_CFG;
    else if (addr == A_SEL)  sel = REG_SEL;
    else if (addr == A_STAT) sel = REG_STAT;
    else                     sel = REG_NONE;
  end
endmodule

// File: rtl/wdg_regs.sv
module wdg_regs
  import wdg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_en,
  input  wdg_reg_e          sel,
  input  logic              wr,
  input  logic              rd,
  input  logic [BE_W-1:0]   be,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output wdg_cfg_t          cfg,
  output logic              winsel,
  output logic              running,
  output logic              acc_err
);
  wdg_cfg_t   cfg_q, cfg_d;
  logic       sel_q, sel_d;
  logic       run_q, run_d;
  logic       active, guarded, full, key_ok;
  logic       cfg_we, sel_we;
  logic [7:0] key;

  always_comb begin
    active  = pwr_en && (wr || rd);
    guarded = (sel == REG_CFG) || (sel == REG_SEL);
    full    = &be;
    key     = wdata[DATA_W-1:KEY_LSB];
    key_ok  = (sel == REG_CFG) ? (key == CFG_KEY) : (key == SEL_KEY);

    acc_err = active && guarded &&
              (!full || (wr && (!key_ok || (sel == REG_CFG && run_q))));

    cfg_we  = pwr_en && wr && full && (sel == REG_CFG) && key_ok && !run_q;
    sel_we  = pwr_en && wr && full && (sel == REG_SEL) && key_ok;

    cfg_d   = cfg_we ? wdg_cfg_t'(wdata[CFG_W-1:0]) : cfg_q;
    sel_d   = sel_we ? wdata[0] : sel_q;
    run_d   = run_q | cfg_we;
  end

  always_comb begin
    rdata = '0;
    if (pwr_en && rd) begin
      unique case (sel)
        REG_CFG:  if (full) rdata[CFG_W-1:0] = cfg_q;
        REG_SEL:  if (full) rdata[0] = sel_q;
        REG_STAT: rdata[0] = run_q;
        default:  rdata = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      sel_q <= 1'b0;
      run_q <= 1'b0;
    end else begin
      if (cfg_we) cfg_q <= cfg_d;
      if (sel_we) sel_q <= sel_d;
      if (cfg_we) run_q <= run_d;
    end
  end

  assign cfg     = cfg_q;
  assign winsel  = sel_q;
  assign running = run_q;
endmodule

// File: rtl/wdg_timer.sv
module wdg_timer
  import wdg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] clkdiv,
  input  logic [PER_W-1:0] per,
  input  logic [WIN_W-1:0] win0,
  input  logic [WIN_W-1:0] win1,
  input  logic             winsel,
  input  logic             tick,
  input  logic             svc,
  output logic             err
);
  logic [CNT_W-1:0] cnt_q, cnt_d, period, closed, thr;
  logic [PRE_W-1:0] pre_q, pre_d, pre_lim;
  logic [WIN_W-1:0] win;
  logic             armed_q, armed_d;
  logic             step, early, svc_ok, expire;

  always_comb begin
    period  = {{(CNT_W-1){1'b0}}, 1'b1} << (BASE_SH + 2 * int'(per));
    win     = winsel ? win1 : win0;
    closed  = (period >> WIN_W) * {{(CNT_W-WIN_W){1'b0}}, win};
    thr     = period - closed;
    pre_lim = ~({PRE_W{1'b1}} << clkdiv);

    early   = armed_q && svc && (cnt_q > thr);
    svc_ok  = armed_q && svc && !early;
    step    = armed_q && tick && (pre_q == pre_lim);
    expire  = step && !svc_ok && (cnt_q == {{(CNT_W-1){1'b0}}, 1'b1});
    err     = early || expire;
  end

  always_comb begin
    cnt_d   = cnt_q;
    pre_d   = pre_q;
    armed_d = run;
    if (run && !armed_q) begin
      cnt_d = period;
      pre_d = '0;
    end else if (armed_q) begin
      if (svc_ok) begin
        cnt_d = period;
        pre_d = '0;
      end else if (tick) begin
        if (step) begin
          pre_d = '0;
          cnt_d = expire ? period : cnt_q - 1'b1;
        end else begin
          pre_d = pre_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      pre_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      armed_q <= armed_d;
      if (run) begin
        cnt_q <= cnt_d;
        pre_q <= pre_d;
      end
    end
  end
endmodule

// File: rtl/wdg_ctrl_if.sv
module wdg_ctrl_if
  import wdg_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic [3:0]        bus_be,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [31:0]       bus_rdata,
  input  logic              tmr_tick,
  input  logic              tmr_svc,
  output logic              wdg_viol
);
  logic [1:0] rst_sync_q;
  logic       rst_sync_n;
  wdg_reg_e   reg_sel;
  wdg_cfg_t   cfg;
  logic       winsel, running, acc_err, tmr_err;
  logic       viol_q, viol_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  wdg_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr (bus_addr),
    .sel  (reg_sel)
  );

  wdg_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .pwr_en  (pwr_en),
    .sel     (reg_sel),
    .wr      (bus_wr),
    .rd      (bus_rd),
    .be      (bus_be),
    .wdata   (bus_wdata),
    .rdata   (bus_rdata),
    .cfg     (cfg),
    .winsel  (winsel),
    .running (running),
    .acc_err (acc_err)
  );

  wdg_timer u_tmr (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .run    (running),
    .clkdiv (cfg.clkdiv),
    .per    (cfg.per),
    .win0   (cfg.win0),
    .win1   (cfg.win1),
    .winsel (winsel),
    .tick   (tmr_tick),
    .svc    (tmr_svc),
    .err    (tmr_err)
  );

  always_comb viol_d = acc_err || tmr_err;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) viol_q <= 1'b0;
    else             viol_q <= viol_d;
  end
  assign wdg_viol = viol_q;
endmodule

// File: rtl/wdg_ctrl_chk.sv
module wdg_ctrl_chk
  import wdg_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic              pwr_en,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [3:0]        bus_be,
  input logic              bus_wr,
  input logic [31:0]       bus_rdata,
  input logic              running,
  input wdg_cfg_t          cfg,
  input logic              tmr_err,
  input logic              wdg_viol
);
  // R5
  run_sticky_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    running |=> running);

  // R6
  cfg_lock_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    running |=> $stable(cfg));

  // R7
  pwr_off_rdata_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !pwr_en |-> (bus_rdata == 32'h0));

  // R4
  key_byte_zero_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    bus_rdata[31:24] == 8'h00);

  // R11
  idle_timer_quiet_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !running |-> !tmr_err);

  // R2
  narrow_write_viol_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (pwr_en && bus_wr && bus_addr == ADDR_W'(OFF_CFG) && bus_be != 4'hF) |=> wdg_viol);
endmodule

bind wdg_ctrl_if wdg_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .pwr_en     (pwr_en),
  .bus_addr   (bus_addr),
  .bus_be     (bus_be),
  .bus_wr     (bus_wr),
  .bus_rdata  (bus_rdata),
  .running    (running),
  .cfg        (cfg),
  .tmr_err    (tmr_err),
  .wdg_viol   (wdg_viol)
);

// File: tb/tb_wdg_ctrl_if.sv
`timescale 1ns/1ps
module tb_wdg_ctrl_if;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pwr_en = 1'b1;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [3:0]  bus_be = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic        tmr_tick = 1'b0;
  logic        tmr_svc = 1'b0;
  logic        wdg_viol;

  int checks = 0;
  int errors = 0;
  int viol_cnt = 0;

  always #5 clk = ~clk;

  wdg_ctrl_if #(.ADDR_W(4)) dut (
    .clk(clk), .rst_n(rst_n), .pwr_en(pwr_en), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_be(bus_be), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_rdata(bus_rdata), .tmr_tick(tmr_tick), .tmr_svc(tmr_svc),
    .wdg_viol(wdg_viol)
  );

  always @(negedge clk) if (wdg_viol === 1'b1) viol_cnt++;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic settle();
    @(negedge clk); #1;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_be = be; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_be = '0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [3:0] be, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_be = be; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0; bus_be = '0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tmr_tick = 1'b1;
    end
    @(negedge clk); tmr_tick = 1'b0;
  endtask

  task automatic service();
    @(negedge clk); tmr_svc = 1'b1;
    @(negedge clk); tmr_svc = 1'b0;
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    checks++; errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    finish_run();
  end

  initial begin
    logic [31:0] d;
    int v0;
    do_reset();

    // R1: reset state
    rd(4'h0, 4'hF, d); chk("R1 cfg", d, 32'h0);
    rd(4'h4, 4'hF, d); chk("R1 sel", d, 32'h0);
    rd(4'h8, 4'hF, d); chk("R1 stat", d, 32'h0);
    settle(); chk("R1 viol", viol_cnt, 0);

    // R7: power-enable low gates everything
    pwr_en = 1'b0;
    v0 = viol_cnt;
    wr(4'h0, 32'hC900_0001, 4'hF);
    wr(4'h0, 32'h1200_0001, 4'h3);
    rd(4'h8, 4'hF, d); chk("R7 stat read zero", d, 32'h0);
    settle(); chk("R7 no viol", viol_cnt - v0, 0);
    pwr_en = 1'b1;
    rd(4'h8, 4'hF, d); chk("R7 not started", d, 32'h0);
    rd(4'h0, 4'hF, d); chk("R7 cfg unchanged", d, 32'h0);

    // R11: timer inputs while stopped
    v0 = viol_cnt;
    service(); ticks(300); service();
    settle(); chk("R11 idle timer", viol_cnt - v0, 0);

    // R3: key sweep on both registers
    v0 = viol_cnt;
    for (int k = 0; k < 256; k++)
      if (k != 8'hBE) wr(4'h4, {8'(k), 24'h1}, 4'hF);
    settle(); chk("R3 sel bad keys", viol_cnt - v0, 255);
    rd(4'h4, 4'hF, d); chk("R3 sel unchanged", d, 32'h0);
    v0 = viol_cnt;
    for (int k = 0; k < 256; k++)
      if (k != 8'hC9) wr(4'h0, {8'(k), 24'h1}, 4'hF);
    settle(); chk("R3 cfg bad keys", viol_cnt - v0, 255);
    rd(4'h8, 4'hF, d); chk("R3 not started", d, 32'h0);

    // R2: strobe sweep
    v0 = viol_cnt;
    for (int b = 0; b < 15; b++) wr(4'h0, 32'hC900_0001, 4'(b));
    settle(); chk("R2 narrow writes", viol_cnt - v0, 15);
    rd(4'h8, 4'hF, d); chk("R2 not started", d, 32'h0);
    v0 = viol_cnt;
    rd(4'h4, 4'h7, d); chk("R2 narrow read data", d, 32'h0);
    settle(); chk("R2 narrow read viol", viol_cnt - v0, 1);

    // R3: valid key on window select
    wr(4'h4, 32'hBE00_0001, 4'hF);
    rd(4'h4, 4'hF, d); chk("R3 sel accepted", d, 32'h1);
    wr(4'h4, 32'hBE00_0000, 4'hF);

    // R5 / R4: start with WINDOW0=4, WINDOW1=0, MODE=1, STISM=1, reserved bits set
    v0 = viol_cnt;
    wr(4'h0, 32'hC9FF_F100, 4'hF);
    rd(4'h0, 4'hF, d); chk("R4 cfg layout", d, 32'h0000_3100);
    rd(4'h8, 4'hF, d); chk("R5 running", d, 32'h1);
    settle(); chk("R5 no viol", viol_cnt - v0, 0);

    // R6: lock
    v0 = viol_cnt;
    wr(4'h0, 32'hC900_0009, 4'hF);
    settle(); chk("R6 locked viol", viol_cnt - v0, 1);
    rd(4'h0, 4'hF, d); chk("R6 cfg kept", d, 32'h0000_3100);
    wr(4'h4, 32'hBE00_0001, 4'hF);
    rd(4'h4, 4'hF, d); chk("R6 sel writable", d, 32'h1);
    wr(4'h4, 32'hBE00_0000, 4'hF);

    // R10: period 256, threshold 256 - 32*4 = 128
    v0 = viol_cnt; service(); settle();
    chk("R10 early at 256", viol_cnt - v0, 1);
    ticks(128);
    v0 = viol_cnt; service(); settle();
    chk("R10 at threshold", viol_cnt - v0, 0);
    ticks(127);
    v0 = viol_cnt; service(); settle();
    chk("R10 one above threshold", viol_cnt - v0, 1);
    ticks(1);
    v0 = viol_cnt; service(); settle();
    chk("R10 early did not reload", viol_cnt - v0, 0);
    wr(4'h4, 32'hBE00_0001, 4'hF);
    v0 = viol_cnt; service(); settle();
    chk("R10 WINDOW1=0 open", viol_cnt - v0, 0);

    // R9: expiry and reload
    v0 = viol_cnt; ticks(255); settle();
    chk("R9 before expiry", viol_cnt - v0, 0);
    v0 = viol_cnt; ticks(1); settle();
    chk("R9 expiry", viol_cnt - v0, 1);
    v0 = viol_cnt; ticks(256); settle();
    chk("R9 reload", viol_cnt - v0, 1);

    // R8: pulse timing
    wr(4'h0, 32'h0000_0000, 4'hF);
    #1 chk("R8 pulse high", {31'h0, wdg_viol}, 32'h1);
    @(negedge clk); #1 chk("R8 pulse low", {31'h0, wdg_viol}, 32'h0);

    // R1: reset while running
    do_reset();
    rd(4'h8, 4'hF, d); chk("R1 stat after reset", d, 32'h0);
    rd(4'h0, 4'hF, d); chk("R1 cfg after reset", d, 32'h0);
    rd(4'h4, 4'hF, d); chk("R1 sel after reset", d, 32'h0);
    v0 = viol_cnt; ticks(300); settle();
    chk("R1 timer stopped", viol_cnt - v0, 0);

    // R9: period and divider sweep
    for (int p = 0; p < 4; p++) begin
      int dv;
      int n;
      dv = p % 2;
      n = (1 << (8 + 2 * p)) << dv;
      do_reset();
      wr(4'h0, {8'hC9, 18'h0, 3'(p), 3'(dv)}, 4'hF);
      repeat (2) @(negedge clk);
      v0 = viol_cnt; ticks(n - 1); settle();
      chk($sformatf("R9 per=%0d div=%0d before", p, dv), viol_cnt - v0, 0);
      v0 = viol_cnt; ticks(1); settle();
      chk($sformatf("R9 per=%0d div=%0d expire", p, dv), viol_cnt - v0, 1);
    end

    finish_run();
  end
endmodule